// File: doc/BRIEF.md
# I2C Controller Interrupt Request Generator

This block turns the status of an I2C controller into its four interrupt requests. It keeps eight status flags. Five of them record bus events: arbitration lost, NACK received, timeout, start seen and stop seen. The other three are receive-full, transmit-empty and transmit-end. The bus engine reports each event with a one-cycle pulse, and that pulse sets the matching flag. Accesses to the data registers, a detected stop, and software writes of 0 to the status register clear the flags again.

There are four requests. The error/event request is a level: the OR of the five event flags, each gated by its own enable. The transmit-end request is also a level, gated by its enable. The receive and transmit requests are single-cycle pulses, raised when the gated flag condition rises. Software therefore never acknowledges them. The same two pulses also serve as trigger strobes for a DMA or transfer controller. A small encoded output names the highest-priority request present in the current cycle.

Top module: `i2cIrqGen`

## Requirements
- R1: After reset, every flag bit of `flagSts` is 0, every request and trigger output is 0, and `irqTopId` is 0.
- R2: An event pulse on `evArbLost`, `evNack`, `evTimeout`, `evStart` or `evStop` sets `flagSts` bit 0, 1, 2, 3 or 4 respectively, one clock edge later. The bit stays set until a cycle with `stsWr` high and a 0 in that bit of `stsWrData` clears it. If a set and a clear of the same bit occur in one cycle, the bit ends up set.
- R3: `irqErrEvt` is high exactly when at least one of `flagSts[4:0]` is 1 together with the same bit of `intEn[4:0]`.
- R4: `evRxFull` sets the receive-full flag (`flagSts` bit 6). `rdRxData` clears it. When both occur in the same cycle, the flag ends up set.
- R5: `evTxEmpty` sets the transmit-empty flag (`flagSts` bit 7). Either `wrTxData` or `evStop` clears it. When a set and a clear occur in the same cycle, the flag ends up set.
- R6: `evTxEnd` sets the transmit-end flag (`flagSts` bit 5). It is cleared by `wrTxData`, by `evStop`, or by `stsWr` with bit 5 of `stsWrData` at 0. A set in the same cycle as a clear wins.
- R7: `irqRx` is high for exactly one cycle: the first cycle in which the receive-full flag AND `intEn[6]` is 1 after a cycle in which it was 0. Holding the condition gives no further pulse.
- R8: `irqTx` follows the same one-cycle rule for the transmit-empty flag AND `intEn[7]`.
- R9: `irqTxEnd` is high exactly while the transmit-end flag and `intEn[5]` are both 1.
- R10: `dmaRxTrig` equals `irqRx` and `dmaTxTrig` equals `irqTx`. Neither the error/event request nor the transmit-end request ever raises a trigger.
- R11: `irqTopId` gives the highest-priority active request: 1 for error/event, 2 for receive, 3 for transmit, 4 for transmit-end, and 0 when none is active.
- R12: Status writes leave bits 6 and 7 of `flagSts` unchanged, whatever value `stsWrData` holds in those bits. A 1 written to any bit also leaves that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evArbLost | input | 1 | Arbitration-lost event pulse |
| evNack | input | 1 | NACK-received event pulse |
| evTimeout | input | 1 | Bus timeout event pulse |
| evStart | input | 1 | Start-condition event pulse |
| evStop | input | 1 | Stop-condition event pulse |
| evRxFull | input | 1 | Received byte now in the receive data register |
| evTxEmpty | input | 1 | Transmit data register now free |
| evTxEnd | input | 1 | Transmission finished with the register empty |
| rdRxData | input | 1 | Software read of the receive data register |
| wrTxData | input | 1 | Software write of the transmit data register |
| stsWr | input | 1 | Software write of the status register |
| stsWrData | input | 8 | Status write data; a 0 clears bits 0 to 5 |
| intEn | input | 8 | Per-flag enables, same bit map as flagSts |
| flagSts | output | 8 | Flag state |
| irqErrEvt | output | 1 | Error/event request (level) |
| irqRx | output | 1 | Receive-full request (one-cycle pulse) |
| irqTx | output | 1 | Transmit-empty request (one-cycle pulse) |
| irqTxEnd | output | 1 | Transmit-end request (level) |
| dmaRxTrig | output | 1 | Transfer trigger from the receive side |
| dmaTxTrig | output | 1 | Transfer trigger from the transmit side |
| irqTopId | output | 3 | Highest-priority active request |

## Verification
The error/event combiner is swept over all 1024 pairs of the five event flags and the five enables, which separates a plain OR of the flags from a correctly gated one. Every combination of the four request sources is raised in a single cycle, which shows whether the priority order and the trigger isolation hold under contention. The three data flags are driven with set alone, clear alone, and set together with clear. Their enables are also toggled while a flag is held, which distinguishes an edge-style pulse from a level and shows that the set-wins rule applies.

// File: rtl/i2cIrqPkg.sv
package i2cIrqPkg;
  localparam int NUM_EVT   = 5;
  localparam int NUM_FLAGS = 8;
  localparam int BIT_TXEND = 5;
  localparam int BIT_RX    = 6;
  localparam int BIT_TX    = 7;
  localparam int ID_W      = 3;

  typedef enum logic [ID_W-1:0] {
    ID_NONE  = 3'd0,
    ID_ERR   = 3'd1,
    ID_RX    = 3'd2,
    ID_TX    = 3'd3,
    ID_TXEND = 3'd4
  } irqId_t;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
  } flagCtl_t;
endpackage

// File: rtl/i2cIrqCtl.sv
module i2cIrqCtl
  import i2cIrqPkg::*;
(
  input  logic [NUM_EVT-1:0]   evtVec,
  input  logic                 evRxFull,
  input  logic                 evTxEmpty,
  input  logic                 evTxEnd,
  input  logic                 evStop,
  input  logic                 rdRxData,
  input  logic                 wrTxData,
  input  logic                 stsWr,
  input  logic [NUM_FLAGS-1:0] stsWrData,
  output flagCtl_t             ctl
);
  // a status write can only clear; a 1 leaves the bit as it is
  logic [NUM_FLAGS-1:0] swClr;
  assign swClr = {NUM_FLAGS{stsWr}} & ~stsWrData;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign ctl.setVec[i] = evtVec[i];
    assign ctl.clrVec[i] = swClr[i];
  end

  assign ctl.setVec[BIT_TXEND] = evTxEnd;
  assign ctl.clrVec[BIT_TXEND] = swClr[BIT_TXEND] | wrTxData | evStop;
  assign ctl.setVec[BIT_RX]    = evRxFull;
  assign ctl.clrVec[BIT_RX]    = rdRxData;
  assign ctl.setVec[BIT_TX]    = evTxEmpty;
  assign ctl.clrVec[BIT_TX]    = wrTxData | evStop;
endmodule

// File: rtl/i2cIrqDp.sv
module i2cIrqDp
  import i2cIrqPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagCtl_t             ctl,
  input  logic [NUM_FLAGS-1:0] intEn,
  output logic [NUM_FLAGS-1:0] flagSts,
  output logic                 irqErrEvt,
  output logic                 irqRx,
  output logic                 irqTx,
  output logic                 irqTxEnd,
  output logic                 dmaRxTrig,
  output logic                 dmaTxTrig,
  output logic [ID_W-1:0]      irqTopId
);
  logic [NUM_FLAGS-1:0] flagQ;
  logic                 rxCondQ;
  logic                 txCondQ;
  logic                 rxCond;
  logic                 txCond;

  // set has priority over clear in the same cycle
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) flagQ[i] <= 1'b0;
      else       flagQ[i] <= ctl.setVec[i] | (flagQ[i] & ~ctl.clrVec[i]);
    end
  end

  assign rxCond = flagQ[BIT_RX] & intEn[BIT_RX];
  assign txCond = flagQ[BIT_TX] & intEn[BIT_TX];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCondQ <= 1'b0;
      txCondQ <= 1'b0;
    end else begin
      rxCondQ <= rxCond;
      txCondQ <= txCond;
    end
  end

  assign flagSts   = flagQ;
  assign irqErrEvt = |(flagQ[NUM_EVT-1:0] & intEn[NUM_EVT-1:0]);
  assign irqRx     = rxCond & ~rxCondQ;
  assign irqTx     = txCond & ~txCondQ;
  assign irqTxEnd  = flagQ[BIT_TXEND] & intEn[BIT_TXEND];
  assign dmaRxTrig = irqRx;
  assign dmaTxTrig = irqTx;

  irqId_t topId;
  always_comb begin
    if (irqErrEvt)     topId = ID_ERR;
    else if (irqRx)    topId = ID_RX;
    else if (irqTx)    topId = ID_TX;
    else if (irqTxEnd) topId = ID_TXEND;
    else               topId = ID_NONE;
  end
  assign irqTopId = topId;
endmodule

// File: rtl/i2cIrqGen.sv
module i2cIrqGen
  import i2cIrqPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evArbLost,
  input  logic                 evNack,
  input  logic                 evTimeout,
  input  logic                 evStart,
  input  logic                 evStop,
  input  logic                 evRxFull,
  input  logic                 evTxEmpty,
  input  logic                 evTxEnd,
  input  logic                 rdRxData,
  input  logic                 wrTxData,
  input  logic                 stsWr,
  input  logic [NUM_FLAGS-1:0] stsWrData,
  input  logic [NUM_FLAGS-1:0] intEn,
  output logic [NUM_FLAGS-1:0] flagSts,
  output logic                 irqErrEvt,
  output logic                 irqRx,
  output logic                 irqTx,
  output logic                 irqTxEnd,
  output logic                 dmaRxTrig,
  output logic                 dmaTxTrig,
  output logic [ID_W-1:0]      irqTopId
);
  flagCtl_t ctl;
  logic [NUM_EVT-1:0] evtVec;
  assign evtVec = {evStop, evStart, evTimeout, evNack, evArbLost};

  i2cIrqCtl u_ctl (
    .evtVec(evtVec), .evRxFull(evRxFull), .evTxEmpty(evTxEmpty),
    .evTxEnd(evTxEnd), .evStop(evStop), .rdRxData(rdRxData),
    .wrTxData(wrTxData), .stsWr(stsWr), .stsWrData(stsWrData), .ctl(ctl)
  );

  i2cIrqDp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .intEn(intEn), .flagSts(flagSts),
    .irqErrEvt(irqErrEvt), .irqRx(irqRx), .irqTx(irqTx), .irqTxEnd(irqTxEnd),
    .dmaRxTrig(dmaRxTrig), .dmaTxTrig(dmaTxTrig), .irqTopId(irqTopId)
  );
endmodule

// File: rtl/i2cIrqGenChk.sv
module i2cIrqGenChk
  import i2cIrqPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 evArbLost,
  input logic                 evStop,
  input logic                 evRxFull,
  input logic                 evTxEmpty,
  input logic                 evTxEnd,
  input logic                 rdRxData,
  input logic                 wrTxData,
  input logic [NUM_FLAGS-1:0] intEn,
  input logic [NUM_FLAGS-1:0] flagSts,
  input logic                 irqErrEvt,
  input logic                 irqRx,
  input logic                 irqTx,
  input logic                 irqTxEnd,
  input logic                 dmaRxTrig,
  input logic                 dmaTxTrig,
  input logic [ID_W-1:0]      irqTopId
);
  assert_arb_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    evArbLost |=> flagSts[0]);
  assert_err_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqErrEvt |-> ((flagSts[NUM_EVT-1:0] & intEn[NUM_EVT-1:0]) != '0));
  assert_rx_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    evRxFull |=> flagSts[BIT_RX]);
  assert_rx_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdRxData && !evRxFull) |=> !flagSts[BIT_RX]);
  assert_tx_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((wrTxData || evStop) && !evTxEmpty) |=> !flagSts[BIT_TX]);
  assert_txend_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((wrTxData || evStop) && !evTxEnd) |=> !flagSts[BIT_TXEND]);
  assert_rx_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqRx |=> !irqRx);
  assert_rx_cond_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqRx |-> (flagSts[BIT_RX] && intEn[BIT_RX]));
  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqTx |=> !irqTx);
  assert_txend_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqTxEnd |-> flagSts[BIT_TXEND]);
  assert_dma_only_rxtx_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRxTrig || dmaTxTrig) |-> (irqRx || irqTx));
  assert_err_top_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqErrEvt |-> (irqTopId == ID_ERR));
  assert_top_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    (irqTopId == ID_NONE) |-> !(irqErrEvt || irqRx || irqTx || irqTxEnd));
endmodule

bind i2cIrqGen i2cIrqGenChk u_chk (
  .clk(clk), .rstN(rstN), .evArbLost(evArbLost), .evStop(evStop),
  .evRxFull(evRxFull), .evTxEmpty(evTxEmpty), .evTxEnd(evTxEnd),
  .rdRxData(rdRxData), .wrTxData(wrTxData), .intEn(intEn), .flagSts(flagSts),
  .irqErrEvt(irqErrEvt), .irqRx(irqRx), .irqTx(irqTx), .irqTxEnd(irqTxEnd),
  .dmaRxTrig(dmaRxTrig), .dmaTxTrig(dmaTxTrig), .irqTopId(irqTopId)
);

// File: tb/i2cIrqGen_tb.sv
`timescale 1ns/1ps
module i2cIrqGen_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evArbLost = 0, evNack = 0, evTimeout = 0, evStart = 0, evStop = 0;
  logic evRxFull = 0, evTxEmpty = 0, evTxEnd = 0;
  logic rdRxData = 0, wrTxData = 0, stsWr = 0;
  logic [7:0] stsWrData = 8'hFF;
  logic [7:0] intEn = 8'h00;
  logic [7:0] flagSts;
  logic irqErrEvt, irqRx, irqTx, irqTxEnd, dmaRxTrig, dmaTxTrig;
  logic [2:0] irqTopId;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2cIrqGen u_dut (
    .clk(clk), .rstN(rstN), .evArbLost(evArbLost), .evNack(evNack),
    .evTimeout(evTimeout), .evStart(evStart), .evStop(evStop),
    .evRxFull(evRxFull), .evTxEmpty(evTxEmpty), .evTxEnd(evTxEnd),
    .rdRxData(rdRxData), .wrTxData(wrTxData), .stsWr(stsWr),
    .stsWrData(stsWrData), .intEn(intEn), .flagSts(flagSts),
    .irqErrEvt(irqErrEvt), .irqRx(irqRx), .irqTx(irqTx), .irqTxEnd(irqTxEnd),
    .dmaRxTrig(dmaRxTrig), .dmaTxTrig(dmaTxTrig), .irqTopId(irqTopId)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    {evArbLost, evNack, evTimeout, evStart, evStop} = '0;
    {evRxFull, evTxEmpty, evTxEnd, rdRxData, wrTxData, stsWr} = '0;
    stsWrData = 8'hFF;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clearAll();
    quiet();
    stsWr = 1; stsWrData = 8'h00; rdRxData = 1; wrTxData = 1;
    step();
    quiet();
    step();
    step();
  endtask

  task automatic evtPulse(input logic [4:0] f);
    {evStop, evStart, evTimeout, evNack, evArbLost} = f;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 flags", flagSts, 8'h00);
    chk("R1 outs", {irqErrEvt, irqRx, irqTx, irqTxEnd, dmaRxTrig, dmaTxTrig}, 8'h00);
    chk("R1 topId", {5'd0, irqTopId}, 8'h00);
    rstN = 1'b1;
    step();

    // R2 R3 R11: exhaustive sweep over event flags and enables
    for (int f = 0; f < 32; f++) begin
      for (int e = 0; e < 32; e++) begin
        intEn = {3'b000, e[4:0]};
        evtPulse(f[4:0]);
        step();
        quiet();
        chk("R2 evtSet", {3'b0, flagSts[4:0]}, {3'b0, f[4:0]});
        chk("R3 errLevel", {7'd0, irqErrEvt}, {7'd0, ((f & e) != 0)});
        chk("R11 errTop", {5'd0, irqTopId}, ((f & e) != 0) ? 8'd1 : 8'd0);
        stsWr = 1; stsWrData = 8'h00;
        step();
        quiet();
        chk("R2 swClr", flagSts, 8'h00);
      end
    end

    // R2 sticky, partial clear, set wins
    intEn = 8'h00;
    evtPulse(5'b11111);
    step(); quiet();
    repeat (4) step();
    chk("R2 sticky", {3'b0, flagSts[4:0]}, 8'h1F);
    stsWr = 1; stsWrData = 8'b1111_1010;
    step(); quiet();
    chk("R2 partClr", {3'b0, flagSts[4:0]}, 8'h1A);
    stsWr = 1; stsWrData = 8'h00; evNack = 1;
    step(); quiet();
    chk("R2 setWins", {3'b0, flagSts[4:0]}, 8'h02);
    clearAll();

    // R4 R7 R10 receive side
    intEn = 8'h40;
    evRxFull = 1; step(); quiet();
    chk("R4 rxSet", {7'd0, flagSts[6]}, 8'd1);
    chk("R7 rxPulse", {6'd0, irqRx, dmaRxTrig}, 8'd3);
    chk("R11 rxTop", {5'd0, irqTopId}, 8'd2);
    step();
    chk("R7 rxOnce", {6'd0, irqRx, dmaRxTrig}, 8'd0);
    evRxFull = 1; step(); quiet();
    chk("R7 rxHeld", {7'd0, irqRx}, 8'd0);
    stsWr = 1; stsWrData = 8'h00; step(); quiet();
    chk("R12 rxNoSw", {7'd0, flagSts[6]}, 8'd1);
    rdRxData = 1; step(); quiet();
    chk("R4 rxClr", {7'd0, flagSts[6]}, 8'd0);
    rdRxData = 1; evRxFull = 1; step(); quiet();
    chk("R4 rxSetWins", {7'd0, flagSts[6]}, 8'd1);
    clearAll();
    intEn = 8'h00;
    evRxFull = 1; step(); quiet();
    chk("R7 rxMasked", {7'd0, irqRx}, 8'd0);
    step();
    intEn = 8'h40; #1;
    chk("R7 rxEnRise", {6'd0, irqRx, dmaRxTrig}, 8'd3);
    step();
    chk("R7 rxEnHeld", {7'd0, irqRx}, 8'd0);
    clearAll();

    // R5 R8 R10 transmit side
    intEn = 8'h80;
    evTxEmpty = 1; step(); quiet();
    chk("R5 txSet", {7'd0, flagSts[7]}, 8'd1);
    chk("R8 txPulse", {6'd0, irqTx, dmaTxTrig}, 8'd3);
    chk("R11 txTop", {5'd0, irqTopId}, 8'd3);
    step();
    chk("R8 txOnce", {6'd0, irqTx, dmaTxTrig}, 8'd0);
    stsWr = 1; stsWrData = 8'h00; step(); quiet();
    chk("R12 txNoSw", {7'd0, flagSts[7]}, 8'd1);
    wrTxData = 1; step(); quiet();
    chk("R5 txWrClr", {7'd0, flagSts[7]}, 8'd0);
    evTxEmpty = 1; step(); quiet();
    chk("R8 txRepulse", {7'd0, irqTx}, 8'd1);
    evStop = 1; step(); quiet();
    chk("R5 txStopClr", {7'd0, flagSts[7]}, 8'd0);
    wrTxData = 1; evTxEmpty = 1; step(); quiet();
    chk("R5 txSetWins", {7'd0, flagSts[7]}, 8'd1);
    clearAll();

    // R6 R9 transmit end
    intEn = 8'h20;
    evTxEnd = 1; step(); quiet();
    chk("R6 endSet", {7'd0, flagSts[5]}, 8'd1);
    step(); step();
    chk("R9 endLevel", {7'd0, irqTxEnd}, 8'd1);
    chk("R11 endTop", {5'd0, irqTopId}, 8'd4);
    chk("R10 endNoDma", {6'd0, dmaRxTrig, dmaTxTrig}, 8'd0);
    stsWr = 1; stsWrData = 8'hFF; step(); quiet();
    chk("R12 oneKeeps", {7'd0, flagSts[5]}, 8'd1);
    stsWr = 1; stsWrData = 8'hDF; step(); quiet();
    chk("R6 endSwClr", {6'd0, flagSts[5], irqTxEnd}, 8'd0);
    evTxEnd = 1; step(); quiet();
    wrTxData = 1; step(); quiet();
    chk("R6 endWrClr", {7'd0, flagSts[5]}, 8'd0);
    evTxEnd = 1; step(); quiet();
    evStop = 1; step(); quiet();
    chk("R6 endStopClr", {7'd0, flagSts[5]}, 8'd0);
    wrTxData = 1; evTxEnd = 1; step(); quiet();
    chk("R6 endSetWins", {7'd0, flagSts[5]}, 8'd1);
    intEn = 8'h00; #1;
    chk("R9 endMasked", {7'd0, irqTxEnd}, 8'd0);
    clearAll();

    // R11 R10: every mix of the four sources in one cycle
    for (int m = 0; m < 16; m++) begin
      logic [7:0] expId;
      intEn = 8'hFF;
      evArbLost = m[0]; evRxFull = m[1]; evTxEmpty = m[2]; evTxEnd = m[3];
      step(); quiet();
      expId = m[0] ? 8'd1 : m[1] ? 8'd2 : m[2] ? 8'd3 : m[3] ? 8'd4 : 8'd0;
      chk("R11 mixTop", {5'd0, irqTopId}, expId);
      chk("R10 mixTrig", {6'd0, dmaRxTrig, dmaTxTrig}, {6'd0, m[1], m[2]});
      chk("R3 R9 mixLvl", {6'd0, irqErrEvt, irqTxEnd}, {6'd0, m[0], m[3]});
      clearAll();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule